// File: doc/BRIEF.md
# Boot Source Selector with Software Override

This block decides which boot source a processing system uses. When power-on reset is released, it latches the four boot-mode strap pins once. It then drives a registered 4-bit effective boot mode, plus three decoded attributes for that mode:

- whether the code is undefined;
- whether secure boot is allowed;
- whether the boot unit runs as master or as slave.

A 20-bit configuration word sits behind a simple APB-style read/write port. It holds an alternate mode field and a select bit. When the select bit is set, the alternate mode replaces the latched straps.

A system soft reset leaves the configuration word untouched. A debugger can therefore write an override, pulse soft reset, and the next boot uses the forced source. Only power-on reset clears the word, and only power-on reset re-arms the strap capture.

The bus port never back-pressures: `bus_ready` is held high. Each access completes in its access phase (`bus_sel` and `bus_enable` both high). A write commits on that clock edge. Read data is driven combinationally while `bus_sel` is high with `bus_write` low. There is no data stream, so every other pin is plain level control or status.

Top module: `bootsel_ctrl`

## Requirements
- R1: After power-on reset, reads of the configuration word at offset 0x200 return zero in bits 19:4 and in bits 31:20.
- R2: The strap pins are sampled only on the first clock edge after `por_n` rises. Later changes on the pins leave the boot mode unchanged until the next power-on reset.
- R3: While the select bit (bit 8) is 0, `boot_mode` and read bits 3:0 equal the captured strap value.
- R4: While the select bit is 1, `boot_mode` equals the alternate field (bits 15:12). The output changes on the first clock edge after the edge that commits the write, not on that edge itself.
- R5: Bits 19:16, 11:9 and 7:4 are read/write storage and read back the last value written. Bits 15:12 and bit 8 also read back as written.
- R6: Write data in bits 3:0 and in bits 31:20 is discarded. Bits 3:0 always read the effective mode, and bits 31:20 always read zero.
- R7: An access at any offset other than 0x200 leaves the word unchanged, and a read there returns zero.
- R8: While `sys_rst_n` is low, writes are ignored. Asserting `sys_rst_n` leaves the word and the boot mode unchanged, and it does not resample the straps.
- R9: The decode of defined codes is as follows. Codes 0x0, 0x8 and 0x9 give `secure_ok`=0 and `boot_master`=0. Code 0x7 gives `secure_ok`=1 and `boot_master`=0. Codes 0x1–0x6 and 0xE give `secure_ok`=1 and `boot_master`=1. All of these give `mode_invalid`=0.
- R10: Codes 0xA–0xD and 0xF give `mode_invalid`=1, `secure_ok`=0 and `boot_master`=0.
- R11: Clearing the select bit returns `boot_mode` to the captured strap value.
- R12: `bus_ready` is 1 during every access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System soft reset, active low |
| strap_pins | input | 4 | Boot-mode strap pins |
| bus_sel | input | 1 | Peripheral select |
| bus_enable | input | 1 | Access phase strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Transfer complete (always 1) |
| boot_mode | output | 4 | Effective boot mode, registered |
| mode_invalid | output | 1 | Effective code is undefined |
| secure_ok | output | 1 | Secure boot allowed for the mode |
| boot_master | output | 1 | 1 = boot unit is master, 0 = slave |

## Verification
The strap path is swept over all sixteen pin codes. Each sweep step uses a fresh power-on reset, and the pins are then flipped to show they are not sampled again. The override path is swept over all sixteen alternate codes with a fixed strap. This separates the two mode sources and covers every row of the attribute decode, including the undefined codes.

Bit patterns are written to the reserved fields and to the discarded bit ranges to check field placement. The following cases are also exercised:
- accesses at a wrong offset;
- writes made while soft reset is held;
- clearing the select bit.

Each of these is checked against a word or mode the bench computes on its own.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;
  localparam int MODE_W = 4;

  typedef logic [MODE_W-1:0] mode_t;

  typedef enum logic [MODE_W-1:0] {
    SRC_DBG_PS    = 4'h0,
    SRC_QSPI_A24  = 4'h1,
    SRC_QSPI_A32  = 4'h2,
    SRC_SD_PORT0  = 4'h3,
    SRC_NAND      = 4'h4,
    SRC_SD_PORT1  = 4'h5,
    SRC_EMMC      = 4'h6,
    SRC_USB       = 4'h7,
    SRC_DBG_MIO_A = 4'h8,
    SRC_DBG_MIO_B = 4'h9,
    SRC_SD1_SHIFT = 4'hE
  } boot_src_e;

  typedef struct packed {
    logic invalid;
    logic secure_ok;
    logic master;
  } mode_attr_t;

  function automatic mode_attr_t decode_mode(input mode_t code);
    mode_attr_t a;
    a = '{invalid: 1'b1, secure_ok: 1'b0, master: 1'b0};
    case (code)
      SRC_DBG_PS, SRC_DBG_MIO_A, SRC_DBG_MIO_B:
        a = '{invalid: 1'b0, secure_ok: 1'b0, master: 1'b0};
      SRC_USB:
        a = '{invalid: 1'b0, secure_ok: 1'b1, master: 1'b0};
      SRC_QSPI_A24, SRC_QSPI_A32, SRC_SD_PORT0, SRC_NAND,
      SRC_SD_PORT1, SRC_EMMC, SRC_SD1_SHIFT:
        a = '{invalid: 1'b0, secure_ok: 1'b1, master: 1'b1};
      default:
        a = '{invalid: 1'b1, secure_ok: 1'b0, master: 1'b0};
    endcase
    return a;
  endfunction
endpackage

// File: rtl/bootsel_strap_latch.sv
module bootsel_strap_latch #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] pins,
  output logic [W-1:0] strap_q,
  output logic         captured
);
  // One-shot capture: armed by power-on reset, fired on the first edge after release.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      strap_q  <= '0;
      captured <= 1'b0;
    end else if (!captured) begin
      strap_q  <= pins;
      captured <= 1'b1;
    end
  end
endmodule

// File: rtl/bootsel_cfg_regs.sv
module bootsel_cfg_regs #(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          REG_W   = 20,
  parameter int          MODE_W  = 4,
  parameter int          ALT_LSB = 12,
  parameter int          SEL_BIT = 8,
  parameter logic [11:0] OFFSET  = 12'h200
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [MODE_W-1:0] eff_mode,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [REG_W-1:MODE_W] cfg_q,
  output logic              use_alt,
  output logic [MODE_W-1:0] alt_mode,
  output logic              wr_hit
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(OFFSET);

  logic addr_hit;
  logic [DATA_W-1:0] rd_word;
  logic unused_wbits;

  assign addr_hit = (bus_addr == HIT_ADDR);
  assign wr_hit   = bus_sel && bus_enable && bus_write && addr_hit && sys_rst_n;

  // Storage covers only the writable span; the low mode field is never stored.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cfg_q <= '0;
    else if (wr_hit) cfg_q <= bus_wdata[REG_W-1:MODE_W];
  end

  assign use_alt  = cfg_q[SEL_BIT];
  assign alt_mode = cfg_q[ALT_LSB +: MODE_W];

  generate
    if (DATA_W > REG_W) begin : g_wide
      assign unused_wbits = ^{bus_wdata[DATA_W-1:REG_W], bus_wdata[MODE_W-1:0]};
    end else begin : g_exact
      assign unused_wbits = ^bus_wdata[MODE_W-1:0];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    rd_word[REG_W-1:MODE_W] = cfg_q;
    rd_word[MODE_W-1:0]     = eff_mode;
  end

  assign bus_rdata = (bus_sel && !bus_write && addr_hit) ? rd_word : '0;
endmodule

// File: rtl/bootsel_mode_select.sv
module bootsel_mode_select
  import bootsel_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       captured,
  input  mode_t      strap_q,
  input  logic       use_alt,
  input  mode_t      alt_mode,
  output mode_t      eff_q,
  output mode_attr_t attr_q
);
  mode_t nxt;

  always_comb begin
    if (!captured)    nxt = '0;
    else if (use_alt) nxt = alt_mode;
    else              nxt = strap_q;
  end

  // Mode and attributes are registered together so they always agree.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      eff_q  <= '0;
      attr_q <= decode_mode('0);
    end else begin
      eff_q  <= nxt;
      attr_q <= decode_mode(nxt);
    end
  end
endmodule

// File: rtl/bootsel_ctrl.sv
module bootsel_ctrl
  import bootsel_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter int          REG_W   = 20,
  parameter int          ALT_LSB = 12,
  parameter int          SEL_BIT = 8,
  parameter logic [11:0] OFFSET  = 12'h200
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic [3:0]        strap_pins,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [3:0]        boot_mode,
  output logic              mode_invalid,
  output logic              secure_ok,
  output logic              boot_master
);
  mode_t                 strap_q;
  logic                  captured;
  logic [REG_W-1:MODE_W] cfg_q;
  logic                  use_alt;
  mode_t                 alt_mode;
  logic                  wr_hit;
  mode_t                 eff_q;
  mode_attr_t            attr_q;

  bootsel_strap_latch #(.W(MODE_W)) u_strap (
    .clk(clk), .por_n(por_n), .pins(strap_pins),
    .strap_q(strap_q), .captured(captured)
  );

  bootsel_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W), .MODE_W(MODE_W),
    .ALT_LSB(ALT_LSB), .SEL_BIT(SEL_BIT), .OFFSET(OFFSET)
  ) u_regs (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .eff_mode(eff_q),
    .bus_rdata(bus_rdata), .cfg_q(cfg_q), .use_alt(use_alt),
    .alt_mode(alt_mode), .wr_hit(wr_hit)
  );

  bootsel_mode_select u_sel (
    .clk(clk), .por_n(por_n), .captured(captured), .strap_q(strap_q),
    .use_alt(use_alt), .alt_mode(alt_mode), .eff_q(eff_q), .attr_q(attr_q)
  );

  assign bus_ready    = 1'b1;
  assign boot_mode    = eff_q;
  assign mode_invalid = attr_q.invalid;
  assign secure_ok    = attr_q.secure_ok;
  assign boot_master  = attr_q.master;
endmodule

// File: rtl/bootsel_ctrl_chk.sv
module bootsel_ctrl_chk (
  input logic        clk,
  input logic        por_n,
  input logic        sys_rst_n,
  input logic        captured,
  input logic [3:0]  strap_q,
  input logic [15:0] cfg_q,
  input logic        wr_hit,
  input logic [3:0]  boot_mode,
  input logic        mode_invalid,
  input logic        secure_ok,
  input logic        boot_master
);
  // R2
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    captured |=> $stable(strap_q));

  // R8
  soft_rst_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> $stable(cfg_q));

  // R7
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!por_n)
    !wr_hit |=> $stable(cfg_q));

  // R4
  alt_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    (captured && cfg_q[4]) |=> (boot_mode == $past(cfg_q[11:8])));

  // R3
  strap_follow_chk: assert property (@(posedge clk) disable iff (!por_n)
    (captured && !cfg_q[4]) |=> (boot_mode == $past(strap_q)));

  // R10
  invalid_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    mode_invalid |-> (!secure_ok && !boot_master));

  // R9
  debug_slave_chk: assert property (@(posedge clk) disable iff (!por_n)
    (boot_mode == 4'h0 || boot_mode == 4'h8 || boot_mode == 4'h9) |-> (!secure_ok && !boot_master && !mode_invalid));
endmodule

bind bootsel_ctrl bootsel_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .captured(captured),
  .strap_q(strap_q), .cfg_q(cfg_q), .wr_hit(wr_hit), .boot_mode(boot_mode),
  .mode_invalid(mode_invalid), .secure_ok(secure_ok), .boot_master(boot_master)
);

// File: tb/bootsel_ctrl_bench.sv
module bootsel_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        sys_rst_n = 1'b1;
  logic [3:0]  strap_pins = '0;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [3:0]  boot_mode;
  logic        mode_invalid, secure_ok, boot_master;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  bootsel_ctrl u_bootsel_ctrl (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .strap_pins(strap_pins),
    .bus_sel(bus_sel), .bus_enable(bus_enable), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .boot_mode(boot_mode), .mode_invalid(mode_invalid),
    .secure_ok(secure_ok), .boot_master(boot_master)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_invalid(input logic [3:0] c);
    return (c >= 4'hA && c <= 4'hD) || c == 4'hF;
  endfunction
  function automatic bit exp_secure(input logic [3:0] c);
    return !exp_invalid(c) && c != 4'h0 && c != 4'h8 && c != 4'h9;
  endfunction
  function automatic bit exp_master(input logic [3:0] c);
    return !exp_invalid(c) && c != 4'h0 && c != 4'h7 && c != 4'h8 && c != 4'h9;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic power_on(input logic [3:0] pins);
    @(negedge clk);
    por_n = 1'b0;
    strap_pins = pins;
    idle(2);
    por_n = 1'b1;
    idle(3);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_enable = 1'b0;
    @(negedge clk);
    bus_enable = 1'b1;
    #1;
    check("R12 ready in write access", {31'b0, bus_ready}, 32'h1);
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a; bus_enable = 1'b0;
    @(negedge clk);
    bus_enable = 1'b1;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0;
  endtask

  task automatic check_attrs(input string req, input logic [3:0] c);
    check(req, {29'b0, mode_invalid, secure_ok, boot_master},
          {29'b0, exp_invalid(c), exp_secure(c), exp_master(c)});
  endtask

  initial begin
    logic [31:0] rd;
    // R2, R3, R1, R9, R10: strap sweep
    for (int s = 0; s < 16; s++) begin
      power_on(4'(s));
      check("R3 strap to boot_mode", {28'b0, boot_mode}, 32'(s));
      check_attrs(exp_invalid(4'(s)) ? "R10 strap attrs" : "R9 strap attrs", 4'(s));
      bus_rd(12'h200, rd);
      check("R1 reset word", rd, 32'(s));
      strap_pins = ~4'(s);
      idle(3);
      check("R2 no resample", {28'b0, boot_mode}, 32'(s));
    end

    // R4 sweep over alternates, strap fixed at 5
    power_on(4'h5);
    for (int n = 0; n < 16; n++) begin
      bus_wr(12'h200, (32'(n) << 12) | 32'h100);
      idle(1);
      check("R4 override mode", {28'b0, boot_mode}, 32'(n));
      check_attrs(exp_invalid(4'(n)) ? "R10 alt attrs" : "R9 alt attrs", 4'(n));
      bus_rd(12'h200, rd);
      check("R5 override readback", rd, (32'(n) << 12) | 32'h100 | 32'(n));
    end

    // R4 update edge: write commits at edge W, output moves at W+1
    bus_wr(12'h200, 32'h0000);
    idle(1);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 12'h200; bus_wdata = 32'h3100;
    @(negedge clk);
    bus_enable = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_enable = 1'b0; bus_write = 1'b0;
    check("R4 not yet on commit edge", {28'b0, boot_mode}, 32'h5);
    @(negedge clk);
    check("R4 on following edge", {28'b0, boot_mode}, 32'h3);

    // R11 clear select
    bus_wr(12'h200, 32'h3000);
    idle(1);
    check("R11 back to strap", {28'b0, boot_mode}, 32'h5);

    // R5, R6 reserved bits and discarded bits
    bus_wr(12'h200, 32'hFFF_A0E5A);
    bus_rd(12'h200, rd);
    check("R5 reserved readback", rd, 32'h000A_0E55);
    bus_wr(12'h200, 32'hFFFF_FFFF);
    idle(1);
    bus_rd(12'h200, rd);
    check("R6 discard high/low bits", rd, 32'h000F_FFFF);
    bus_wr(12'h200, 32'h0000_00F0);
    bus_rd(12'h200, rd);
    check("R5 nibble 7:4 only", rd, 32'h0000_00F5);

    // R7 wrong offset
    bus_wr(12'h204, 32'h0000_7100);
    idle(1);
    bus_rd(12'h200, rd);
    check("R7 stray write no effect", rd, 32'h0000_00F5);
    bus_rd(12'h204, rd);
    check("R7 stray read zero", rd, 32'h0);

    // R8 soft reset keeps override
    bus_wr(12'h200, 32'h0000_1100);
    idle(1);
    @(negedge clk);
    sys_rst_n = 1'b0;
    strap_pins = 4'h2;
    bus_wr(12'h200, 32'h0000_0000);
    idle(2);
    check("R8 mode kept in soft reset", {28'b0, boot_mode}, 32'h1);
    sys_rst_n = 1'b1;
    idle(2);
    bus_rd(12'h200, rd);
    check("R8 word kept after soft reset", rd, 32'h0000_1101);
    bus_wr(12'h200, 32'h0);
    idle(1);
    check("R8 straps not resampled", {28'b0, boot_mode}, 32'h5);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule